// File: doc/BRIEF.md
# Command-Response Buffer Control Registers

This block holds the control and status registers through which software drives a security coprocessor that exchanges commands and responses through a shared memory buffer. Software claims a locality, moves the coprocessor out of idle, places a command in the buffer and then writes the start register. The block hands the launch to a backend engine as a single-cycle request. It forwards cancel requests while a command is running, and it records completion and any error the backend reports.

The register set repeats in every 4 KB page of a 64 KB window. The page number gives the locality of each write. Reads are combinational. A read returns the addressed 32-bit word shifted down by its byte offset, so byte, halfword and word accesses all work. A write acts only when its byte offset is zero and its value, masked to the access size, equals one of the defined command codes.

Top module: `crb_regif`

## Requirements
- R1: The locality of a write is `addr_i[15:12]`. A start write launches only when its page equals the assigned active locality.
- R2: A write to the control-request register (offset 0x40) of exactly 1 clears the idle bit (bit1 of control status, offset 0x44). A write of exactly 2 sets the idle bit. Any other value leaves the idle bit unchanged.
- R3: A write of exactly 1 to the start register (offset 0x4C) launches only when all three of these hold: the busy bit (bit0 of that register) is clear, a locality is assigned, and R1 matches. A launch sets the busy bit and raises `start_req_o` for exactly the one cycle after the write edge.
- R4: A write of exactly 1 to the cancel register (offset 0x48) raises `cancel_req_o` for one cycle, but only while the busy bit is set. Otherwise the write has no effect. The cancel register reads as zero.
- R5: `done_i` clears the busy bit. If `err_i` is high in the same cycle, fatal (bit0 of control status) is set and stays set until reset.
- R6: In the locality-control register (offset 0x08), a value of 1 sets granted (bit0 of locality status, offset 0x0C), clears seized (bit1 of locality status), sets assigned and records the writer's page as the active locality. A value of 2 clears assigned and granted. All other values, including 8, have no effect.
- R7: `active_loc_o` is the active locality when a locality is assigned, and 0xFF when none is assigned.
- R8: A read returns the word at `addr_i` with bits [1:0] cleared, shifted right by 8 times `addr_i[1:0]`. Write data is masked to the access size `size_i+1` bytes before it is decoded.
- R9: The locality-state register (offset 0x00) reads with bit0 = inverse of `established_i`, bit1 = assigned, bits[5:2] = active locality and bit7 = register-valid.
- R10: After reset the following values read back. Locality state has only register-valid set, plus bit0 from R9. Control status is 0x2. The busy bit and locality status are 0. The interface ID (offset 0x30) is 0x00025811. Command size (0x58) and response size (0x64) are 0xF80. Command address (0x5C) and response address (0x68) are 0xFED40080.
- R11: Undefined offsets read zero. Writes to them, and writes with a nonzero byte offset, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 16 | Byte address: page = locality, low 12 bits = offset |
| size_i | input | 2 | Access size minus one, in bytes |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Read data, combinational |
| start_req_o | output | 1 | Command launch pulse to the backend |
| cancel_req_o | output | 1 | Cancel pulse to the backend |
| done_i | input | 1 | Backend completion pulse |
| err_i | input | 1 | Completion status is nonzero, valid with done_i |
| established_i | input | 1 | Established flag from the backend |
| active_loc_o | output | 8 | Active locality, or 0xFF when unassigned |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 4-bit locality field, 4 KB pages, a 0x1000-byte window with the data buffer at 0x80, and base 0xFED40000. Those values make the reset size and address words distinct. The 4-bit page field makes it possible to claim a locality other than zero and then try a launch from a mismatching page. Byte, halfword and offset reads of the multi-field words are covered, and so is a masked single-byte write whose upper byte would otherwise spoil the command code.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int unsigned OFF_W = 12;

  localparam logic [OFF_W-1:0] OFF_LOC_STATE = 12'h000;
  localparam logic [OFF_W-1:0] OFF_LOC_CTRL  = 12'h008;
  localparam logic [OFF_W-1:0] OFF_LOC_STS   = 12'h00C;
  localparam logic [OFF_W-1:0] OFF_INTF_ID   = 12'h030;
  localparam logic [OFF_W-1:0] OFF_CTRL_REQ  = 12'h040;
  localparam logic [OFF_W-1:0] OFF_CTRL_STS  = 12'h044;
  localparam logic [OFF_W-1:0] OFF_CANCEL    = 12'h048;
  localparam logic [OFF_W-1:0] OFF_START     = 12'h04C;
  localparam logic [OFF_W-1:0] OFF_CMD_SIZE  = 12'h058;
  localparam logic [OFF_W-1:0] OFF_CMD_ADDR  = 12'h05C;
  localparam logic [OFF_W-1:0] OFF_RSP_SIZE  = 12'h064;
  localparam logic [OFF_W-1:0] OFF_RSP_ADDR  = 12'h068;

  localparam logic [31:0] CODE_REQ_ACCESS = 32'h1;
  localparam logic [31:0] CODE_RELINQUISH = 32'h2;
  localparam logic [31:0] CODE_CMD_READY  = 32'h1;
  localparam logic [31:0] CODE_GO_IDLE    = 32'h2;
  localparam logic [31:0] CODE_INVOKE     = 32'h1;

  typedef struct packed {
    logic [3:0] if_type;
    logic [3:0] if_ver;
    logic       cap_loc;
    logic       cap_bypass;
    logic       rsvd0;
    logic [1:0] cap_xfer;
    logic       cap_fifo;
    logic       cap_crb;
    logic       rsvd1;
    logic [1:0] selector;
    logic [4:0] rsvd2;
    logic [7:0] rev;
  } intf_id_t;

  function automatic logic [31:0] intf_id_word();
    logic [31:0] w;
    w = '0;
    w[3:0]   = 4'd1;   // crb active
    w[7:4]   = 4'd1;   // version
    w[8]     = 1'b0;   // locality 0 only
    w[9]     = 1'b0;   // no idle bypass
    w[12:11] = 2'b11;  // 64-byte transfers
    w[13]    = 1'b0;   // no fifo
    w[14]    = 1'b1;   // crb supported
    w[18:17] = 2'd1;   // selector
    w[31:24] = 8'd0;   // revision
    return w;
  endfunction
endpackage

// File: rtl/crb_loc_ctl.sv
module crb_loc_ctl #(
  parameter int unsigned LOC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [31:0]      wval_i,
  input  logic [LOC_W-1:0] page_i,
  output logic             assigned_o,
  output logic             granted_o,
  output logic             seized_o,
  output logic [LOC_W-1:0] act_o
);
  import crb_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      assigned_o <= 1'b0;
      granted_o  <= 1'b0;
      seized_o   <= 1'b0;
      act_o      <= '0;
    end else if (wr_i) begin
      if (wval_i == CODE_REQ_ACCESS) begin
        assigned_o <= 1'b1;
        granted_o  <= 1'b1;
        seized_o   <= 1'b0;
        act_o      <= page_i;
      end else if (wval_i == CODE_RELINQUISH) begin
        assigned_o <= 1'b0;
        granted_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crb_exec_ctl.sv
module crb_exec_ctl #(
  parameter int unsigned LOC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_wr_i,
  input  logic             start_wr_i,
  input  logic             cancel_wr_i,
  input  logic [31:0]      wval_i,
  input  logic [LOC_W-1:0] page_i,
  input  logic             assigned_i,
  input  logic [LOC_W-1:0] act_i,
  input  logic             done_i,
  input  logic             err_i,
  output logic             idle_o,
  output logic             fatal_o,
  output logic             busy_o,
  output logic             start_req_o,
  output logic             cancel_req_o
);
  import crb_pkg::*;

  logic launch, cancel_ok;

  assign launch    = start_wr_i && (wval_i == CODE_INVOKE) && !busy_o &&
                     assigned_i && (act_i == page_i);
  assign cancel_ok = cancel_wr_i && (wval_i == CODE_INVOKE) && busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_o       <= 1'b1;
      fatal_o      <= 1'b0;
      busy_o       <= 1'b0;
      start_req_o  <= 1'b0;
      cancel_req_o <= 1'b0;
    end else begin
      start_req_o  <= launch;
      cancel_req_o <= cancel_ok;
      if (req_wr_i && wval_i == CODE_CMD_READY) idle_o <= 1'b0;
      else if (req_wr_i && wval_i == CODE_GO_IDLE) idle_o <= 1'b1;
      if (launch) busy_o <= 1'b1;
      else if (done_i) busy_o <= 1'b0;
      if (done_i && err_i) fatal_o <= 1'b1;
    end
  end
endmodule

// File: rtl/crb_read_mux.sv
module crb_read_mux #(
  parameter int unsigned LOC_W     = 4,
  parameter logic [31:0] WIN_BYTES = 32'h1000,
  parameter logic [31:0] BUF_OFF   = 32'h80,
  parameter logic [31:0] BASE_ADDR = 32'hFED40000
) (
  input  logic [crb_pkg::OFF_W-1:0] off_i,
  input  logic                      established_i,
  input  logic                      assigned_i,
  input  logic [LOC_W-1:0]          act_i,
  input  logic                      granted_i,
  input  logic                      seized_i,
  input  logic                      idle_i,
  input  logic                      fatal_i,
  input  logic                      busy_i,
  output logic [31:0]               rdata_o
);
  import crb_pkg::*;

  localparam logic [31:0] BUF_SIZE = WIN_BYTES - BUF_OFF;
  localparam logic [31:0] BUF_ADDR = BASE_ADDR + BUF_OFF;

  logic [OFF_W-1:0] word_off;
  logic [31:0]      word;

  assign word_off = {off_i[OFF_W-1:2], 2'b00};

  always_comb begin
    word = '0;
    unique case (word_off)
      OFF_LOC_STATE: begin
        word[0]         = ~established_i;
        word[1]         = assigned_i;
        word[2+:LOC_W]  = act_i;
        word[7]         = 1'b1;
      end
      OFF_LOC_STS:  word[1:0] = {seized_i, granted_i};
      OFF_INTF_ID:  word = intf_id_word();
      OFF_CTRL_STS: word[1:0] = {idle_i, fatal_i};
      OFF_START:    word[0] = busy_i;
      OFF_CMD_SIZE, OFF_RSP_SIZE: word = BUF_SIZE;
      OFF_CMD_ADDR, OFF_RSP_ADDR: word = BUF_ADDR;
      default:      word = '0;
    endcase
  end

  assign rdata_o = word >> {off_i[1:0], 3'b000};
endmodule

// File: rtl/crb_regif.sv
module crb_regif #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LOC_W     = 4,
  parameter logic [31:0] WIN_BYTES = 32'h1000,
  parameter logic [31:0] BUF_OFF   = 32'h80,
  parameter logic [31:0] BASE_ADDR = 32'hFED40000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              start_req_o,
  output logic              cancel_req_o,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              established_i,
  output logic [7:0]        active_loc_o
);
  import crb_pkg::*;

  logic [OFF_W-1:0] off;
  logic [LOC_W-1:0] page;
  logic [31:0]      wmask, wval;
  logic             wr_ok;
  logic             assigned, granted, seized, idle, fatal, busy;
  logic [LOC_W-1:0] act;

  assign off   = addr_i[OFF_W-1:0];
  assign page  = addr_i[OFF_W+:LOC_W];
  assign wr_ok = req_i && we_i && (off[1:0] == 2'b00);

  for (genvar b = 0; b < 4; b++) begin : g_mask
    assign wmask[8*b+:8] = (size_i >= 2'(b)) ? 8'hFF : 8'h00;
  end
  assign wval = wdata_i & wmask;

  crb_loc_ctl #(.LOC_W(LOC_W)) u_loc (
    .clk_i, .rst_ni,
    .wr_i      (wr_ok && off == OFF_LOC_CTRL),
    .wval_i    (wval),
    .page_i    (page),
    .assigned_o(assigned),
    .granted_o (granted),
    .seized_o  (seized),
    .act_o     (act)
  );

  crb_exec_ctl #(.LOC_W(LOC_W)) u_exec (
    .clk_i, .rst_ni,
    .req_wr_i    (wr_ok && off == OFF_CTRL_REQ),
    .start_wr_i  (wr_ok && off == OFF_START),
    .cancel_wr_i (wr_ok && off == OFF_CANCEL),
    .wval_i      (wval),
    .page_i      (page),
    .assigned_i  (assigned),
    .act_i       (act),
    .done_i, .err_i,
    .idle_o      (idle),
    .fatal_o     (fatal),
    .busy_o      (busy),
    .start_req_o, .cancel_req_o
  );

  crb_read_mux #(
    .LOC_W(LOC_W), .WIN_BYTES(WIN_BYTES), .BUF_OFF(BUF_OFF), .BASE_ADDR(BASE_ADDR)
  ) u_rd (
    .off_i(off), .established_i,
    .assigned_i(assigned), .act_i(act), .granted_i(granted), .seized_i(seized),
    .idle_i(idle), .fatal_i(fatal), .busy_i(busy),
    .rdata_o
  );

  assign active_loc_o = assigned ? {{(8-LOC_W){1'b0}}, act} : 8'hFF;
endmodule

// File: rtl/crb_regif_chk.sv
module crb_regif_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_req_o,
  input logic       cancel_req_o,
  input logic       done_i,
  input logic       err_i,
  input logic       busy,
  input logic       fatal,
  input logic       assigned,
  input logic [7:0] active_loc_o
);
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |=> !start_req_o);
  a_r3_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> busy && !$past(busy));
  a_r4_cancel_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_req_o |-> $past(busy));
  a_r5_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy) |=> !busy);
  a_r5_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && err_i) |=> fatal);
  a_r7_no_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(assigned) |-> active_loc_o == 8'hFF);
endmodule

bind crb_regif crb_regif_chk u_chk (
  .clk_i, .rst_ni, .start_req_o, .cancel_req_o, .done_i, .err_i,
  .busy(busy), .fatal(fatal), .assigned(assigned), .active_loc_o
);

// File: tb/sim_crb_regif.sv
module sim_crb_regif;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0, done = 0, err = 0, est = 1;
  logic [15:0] addr = 0;
  logic [1:0]  size = 3;
  logic [31:0] wdata = 0, rdata;
  logic        sreq, creq;
  logic [7:0]  aloc;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  bit m_assigned = 0, m_granted = 0, m_idle = 1, m_fatal = 0, m_busy = 0;
  int m_act = 0;
  bit e_sreq = 0, e_creq = 0;

  always #(CLK_NS/2) clk = ~clk;

  crb_regif u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .start_req_o(sreq),
    .cancel_req_o(creq), .done_i(done), .err_i(err), .established_i(est),
    .active_loc_o(aloc)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(int off);
    logic [31:0] w = 0;
    case (off & 12'hFFC)
      12'h000: begin w[0] = ~est; w[1] = m_assigned; w[5:2] = 4'(m_act); w[7] = 1; end
      12'h00C: w[0] = m_granted;
      12'h030: w = 32'h00025811;
      12'h044: begin w[0] = m_fatal; w[1] = m_idle; end
      12'h04C: w[0] = m_busy;
      12'h058, 12'h064: w = 32'hF80;
      12'h05C, 12'h068: w = 32'hFED40080;
      default: w = 0;
    endcase
    return w >> (8 * (off & 3));
  endfunction

  task automatic model_edge();
    logic [31:0] v;
    int pg, off;
    bit launch = 0, canc = 0;
    v   = wdata & ((size == 0) ? 32'hFF : (size == 1) ? 32'hFFFF : (size == 2) ? 32'hFF_FFFF : 32'hFFFF_FFFF);
    pg  = addr[15:12];
    off = addr[11:0];
    if (req && we) begin
      if (off == 12'h040 && v == 1) m_idle = 0;
      if (off == 12'h040 && v == 2) m_idle = 1;
      if (off == 12'h04C && v == 1 && !m_busy && m_assigned && m_act == pg) launch = 1;
      if (off == 12'h048 && v == 1 && m_busy) canc = 1;
      if (off == 12'h008 && v == 1) begin m_assigned = 1; m_granted = 1; m_act = pg; end
      if (off == 12'h008 && v == 2) begin m_assigned = 0; m_granted = 0; end
    end
    if (done && err) m_fatal = 1;
    if (launch) m_busy = 1; else if (done) m_busy = 0;
    e_sreq = launch;
    e_creq = canc;
  endtask

  // one clock; per-cycle comparison of the backend and locality outputs
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 start_req", 32'(sreq), 32'(e_sreq));
    chk("R4 cancel_req", 32'(creq), 32'(e_creq));
    chk("R7 active_loc", 32'(aloc), m_assigned ? 32'(m_act) : 32'hFF);
    req = 0; we = 0; done = 0; err = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d, logic [1:0] s = 3);
    req = 1; we = 1; addr = a; wdata = d; size = s;
    tick();
  endtask

  task automatic rd(string tag, logic [15:0] a, logic [31:0] exp_chk = 32'hDEAD_BEEF, bit use_exp = 0);
    req = 1; we = 0; addr = a; size = 3;
    #1;
    chk(tag, rdata, model_word(int'(a[11:0])));
    if (use_exp) chk(tag, rdata, exp_chk);
    tick();
  endtask

  task automatic finish_done(bit e);
    done = 1; err = e;
    tick();
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    rd("R10 loc_state", 16'h0000, 32'h80, 1);
    rd("R10 intf_id", 16'h0030, 32'h00025811, 1);
    rd("R10 ctrl_sts", 16'h0044, 32'h2, 1);
    rd("R10 start", 16'h004C, 32'h0, 1);
    rd("R10 loc_sts", 16'h000C, 32'h0, 1);
    rd("R10 cmd_size", 16'h0058, 32'hF80, 1);
    rd("R10 cmd_addr", 16'h005C, 32'hFED40080, 1);
    rd("R10 rsp_size", 16'h3064, 32'hF80, 1);
    rd("R10 rsp_addr", 16'h0068, 32'hFED40080, 1);
    chk("R7 reset sentinel", 32'(aloc), 32'hFF);
    // R9 established flag inverted
    est = 0;
    rd("R9 loc_state est0", 16'h0000, 32'h81, 1);
    est = 1;
    // R8 byte-offset reads
    rd("R8 intf byte1", 16'h0031, 32'h258, 1);
    rd("R8 intf byte3", 16'h0033, 32'h0, 1);
    rd("R8 cmd_addr half", 16'h005E, 32'hFED4, 1);
    // R11 undefined offsets
    wr(16'h0010, 32'h1);
    rd("R11 undef", 16'h0010, 32'h0, 1);
    wr(16'h0041, 32'h1);
    rd("R11 misaligned ignored", 16'h0044, 32'h2, 1);
    // R3 no locality
    wr(16'h004C, 32'h1);
    rd("R3 no loc no launch", 16'h004C, 32'h0, 1);
    // R2 idle handshake
    wr(16'h0040, 32'h3);
    rd("R2 other ignored", 16'h0044, 32'h2, 1);
    wr(16'h0040, 32'h1);
    rd("R2 cmd ready", 16'h0044, 32'h0, 1);
    wr(16'h0040, 32'h2);
    rd("R2 go idle", 16'h0044, 32'h2, 1);
    // R6 request from page 2
    wr(16'h2008, 32'h1);
    rd("R6 loc_sts granted", 16'h000C, 32'h1, 1);
    rd("R9 loc_state assigned", 16'h0000, 32'h8A, 1);
    chk("R7 active page2", 32'(aloc), 32'h2);
    // R1 page mismatch
    wr(16'h004C, 32'h1);
    rd("R1 mismatch no launch", 16'h004C, 32'h0, 1);
    wr(16'h204C, 32'h3);
    rd("R3 value 3 ignored", 16'h204C, 32'h0, 1);
    // R4 cancel while idle
    wr(16'h2048, 32'h1);
    // R3 launch
    wr(16'h204C, 32'h1);
    rd("R3 busy set", 16'h004C, 32'h1, 1);
    wr(16'h204C, 32'h1);
    // R4 cancel in flight
    wr(16'h2048, 32'h1);
    rd("R4 cancel reads zero", 16'h0048, 32'h0, 1);
    // R5 completion
    finish_done(0);
    rd("R5 done clears", 16'h004C, 32'h0, 1);
    rd("R5 no fatal", 16'h0044, 32'h2, 1);
    wr(16'h2048, 32'h1);
    wr(16'h204C, 32'h1);
    finish_done(1);
    rd("R5 fatal set", 16'h0044, 32'h3, 1);
    finish_done(0);
    rd("R5 fatal sticky", 16'h0044, 32'h3, 1);
    // R6 other codes and relinquish
    wr(16'h2008, 32'h8);
    rd("R6 code8 ignored", 16'h000C, 32'h1, 1);
    wr(16'h2008, 32'h2);
    rd("R6 relinquish", 16'h000C, 32'h0, 1);
    chk("R7 sentinel after relinquish", 32'(aloc), 32'hFF);
    // R8 byte write masks upper data
    wr(16'h5008, 32'h101, 2'd0);
    rd("R8 masked byte write", 16'h000C, 32'h1, 1);
    chk("R6 page5 active", 32'(aloc), 32'h5);
    wr(16'h504C, 32'h1);
    rd("R1 page5 launch", 16'h004C, 32'h1, 1);
    finish_done(0);
    tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule